// File: doc/BRIEF.md
# Dual-Integrator Conversion Sequencer

This block drives the switch network of a two-channel charge-integrating front end. Each channel owns two integrators, side A and side B. The two sides alternate so that charge collection never pauses. An external select line picks which side collects. The other side, called the idle side, hands its two held voltages to a single shared converter, one channel after the other. It then clears its feedback capacitors and waits until it is called back to integrate.

The select line is asynchronous to the block clock, so it passes through a two-stage synchronizer first. Each time the synchronized select changes, the sequencer swaps the sides. At the swap it also samples two inputs: the test-charge request, which it routes to the side that starts integrating, and the 3-bit full-scale range code, which it decodes for the new integration period. The converter itself is not modelled. Each conversion is a fixed busy window of `CONV_CYCLES` clocks. A one-clock strobe marks the moment both results of a side are available.

If the select changes while the idle side is still being converted, the block does not abandon those conversions. It raises a sticky overrun flag, finishes both conversions, and only then performs the swap.

Top module: `dual_integ_sequencer`

## Requirements
- R1: Integrator index is 2*side + channel, with side A = 0, side B = 1, channel 1 = 0 and channel 2 = 1. While the synchronized select is high, `sw_int` is 4'b0011 (side A integrates). While it is low, `sw_int` is 4'b1100 (side B integrates).
- R2: `conv_sel` passes through two flip-flops. A change driven before clock edge k shows up on the switch outputs after edge k+2, and not earlier.
- R3: At a swap, the idle side converts channel 1 for `CONV_CYCLES` clocks and then channel 2 for `CONV_CYCLES` clocks. The converting integrator has `sw_adc` and `sw_ref` set. Its idle partner has no switch closed (wait).
- R4: At most one bit of `sw_adc` is set, and `mux_sel` equals the index of that integrator.
- R5: After the second conversion, both idle integrators close `sw_rst` and `sw_ref` for `RESET_CYCLES` clocks. After that, all their switches are open (wait).
- R6: The range code is latched at each swap. `ext_cap` is high for code 0. For codes 1 to 7, `int_range` is one-hot with bit (code-1) set.
- R7: The test request is latched at each swap into `test_inj`: bit 0 is side A, bit 1 is side B. Only the newly integrating side's bit can be set.
- R8: `sw_rst` and `sw_int` are never both set on the same integrator.
- R9: `result_ready` is high for exactly one clock, in the first cycle after the second conversion of a side ends.
- R10: A synchronized select change during a conversion sets `overrun`, which stays set until reset. The ongoing conversions complete, and the swap is deferred until the second one ends.
- R11: After reset: side B integrates, side A waits, `sw_adc`, `sw_rst`, `test_inj`, `result_ready` and `overrun` are zero, and `ext_cap` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_sel | input | 1 | Asynchronous side select: high means side A integrates |
| test_en | input | 1 | Test-charge request, sampled at each swap |
| range_code | input | RANGE_W | Full-scale range code, sampled at each swap |
| sw_rst | output | 4 | Capacitor reset switch per integrator |
| sw_int | output | 4 | Input integrate switch per integrator |
| sw_ref | output | 4 | Reference switch per integrator |
| sw_adc | output | 4 | Converter connect switch per integrator |
| mux_sel | output | 2 | Converter multiplexer select (integrator index) |
| test_inj | output | 2 | Test-charge enable per side |
| ext_cap | output | 1 | External capacitor selected |
| int_range | output | 2**RANGE_W-1 | One-hot internal range select |
| result_ready | output | 1 | One-clock strobe when both results of a side are done |
| overrun | output | 1 | Sticky flag: select changed during conversion |

## Verification
The bench instantiates the block with `CONV_CYCLES` = 8 and `RESET_CYCLES` = 4 instead of the full-length defaults. With these values, a complete convert–convert–reset sequence fits in about twenty clocks, so every phase boundary can be sampled on its exact cycle. The short window also makes it easy to toggle the select in the middle of a conversion, which exercises the overrun path and the deferred swap.

// File: rtl/disq_pkg.sv
package disq_pkg;

    localparam int NUM_INTEG = 4;
    localparam int MUX_W     = 2;

    typedef enum logic [1:0] {
        PH_CONV1 = 2'd0,
        PH_CONV2 = 2'd1,
        PH_CLEAR = 2'd2,
        PH_PARK  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        CFG_INTEG,
        CFG_WAIT,
        CFG_CONV,
        CFG_CLEAR
    } cfg_e;

    typedef struct packed {
        logic clr;
        logic integ;
        logic vref;
        logic adc;
    } sw_t;

    // switch pattern of one front-end configuration
    function automatic sw_t cfg_to_sw(cfg_e c);
        sw_t s;
        s = '0;
        case (c)
            CFG_INTEG: s.integ = 1'b1;
            CFG_CONV:  begin s.adc = 1'b1; s.vref = 1'b1; end
            CFG_CLEAR: begin s.clr = 1'b1; s.vref = 1'b1; end
            default:   s = '0;
        endcase
        return s;
    endfunction

    // configuration of integrator (side, chan) given sequencer state
    function automatic cfg_e integ_cfg(logic side, logic chan,
                                       logic active_side, phase_e ph);
        cfg_e c;
        if (side == active_side) begin
            c = CFG_INTEG;
        end else begin
            case (ph)
                PH_CONV1: c = (chan == 1'b0) ? CFG_CONV : CFG_WAIT;
                PH_CONV2: c = (chan == 1'b1) ? CFG_CONV : CFG_WAIT;
                PH_CLEAR: c = CFG_CLEAR;
                default:  c = CFG_WAIT;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/disq_sync.sv
module disq_sync (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= 1'b0;
            d_sync <= 1'b0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/disq_ctrl.sv
module disq_ctrl
    import disq_pkg::*;
#(
    parameter int CONV_CYCLES  = 2200,
    parameter int RESET_CYCLES = 100,
    parameter int RANGE_W      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_s,
    input  logic               test_en,
    input  logic [RANGE_W-1:0] range_code,
    output logic               active_side,
    output phase_e             phase,
    output logic [1:0]         test_inj,
    output logic [RANGE_W-1:0] range_q,
    output logic               result_ready,
    output logic               overrun
);
    localparam int LONGEST = (CONV_CYCLES > RESET_CYCLES) ? CONV_CYCLES : RESET_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] CLEAR_LAST = CNT_W'(RESET_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             sel_d;
    logic             want_side;
    logic             swap_due;
    logic             converting;
    logic             conv2_end;

    always_comb begin
        want_side  = ~sel_s;
        converting = (phase == PH_CONV1) || (phase == PH_CONV2);
        conv2_end  = (phase == PH_CONV2) && (cnt == CONV_LAST);
        swap_due   = (want_side != active_side) && (!converting || conv2_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_side  <= 1'b1;
            phase        <= PH_PARK;
            cnt          <= '0;
            sel_d        <= 1'b0;
            test_inj     <= 2'b00;
            range_q      <= '0;
            result_ready <= 1'b0;
            overrun      <= 1'b0;
        end else begin
            sel_d        <= sel_s;
            result_ready <= conv2_end;
            if (converting && (sel_s != sel_d))
                overrun <= 1'b1;
            if (swap_due) begin
                active_side <= want_side;
                phase       <= PH_CONV1;
                cnt         <= '0;
                test_inj    <= test_en ? (want_side ? 2'b10 : 2'b01) : 2'b00;
                range_q     <= range_code;
            end else begin
                case (phase)
                    PH_CONV1: begin
                        if (cnt == CONV_LAST) begin
                            phase <= PH_CONV2;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    PH_CONV2: begin
                        if (cnt == CONV_LAST) begin
                            phase <= PH_CLEAR;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    PH_CLEAR: begin
                        if (cnt == CLEAR_LAST) begin
                            phase <= PH_PARK;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/disq_decode.sv
module disq_decode
    import disq_pkg::*;
#(
    parameter int RANGE_W = 3
) (
    input  logic                  active_side,
    input  phase_e                phase,
    input  logic [RANGE_W-1:0]    range_q,
    output logic [NUM_INTEG-1:0]  sw_rst,
    output logic [NUM_INTEG-1:0]  sw_int,
    output logic [NUM_INTEG-1:0]  sw_ref,
    output logic [NUM_INTEG-1:0]  sw_adc,
    output logic [MUX_W-1:0]      mux_sel,
    output logic                  ext_cap,
    output logic [(2**RANGE_W)-2:0] int_range
);
    localparam int NUM_RANGES = (2**RANGE_W) - 1;

    for (genvar g = 0; g < NUM_INTEG; g++) begin : g_integ
        localparam logic SIDE = 1'((g / 2) % 2);
        localparam logic CHAN = 1'(g % 2);
        sw_t s;
        always_comb begin
            s         = cfg_to_sw(integ_cfg(SIDE, CHAN, active_side, phase));
            sw_rst[g] = s.clr;
            sw_int[g] = s.integ;
            sw_ref[g] = s.vref;
            sw_adc[g] = s.adc;
        end
    end

    for (genvar r = 0; r < NUM_RANGES; r++) begin : g_range
        assign int_range[r] = (range_q == RANGE_W'(r + 1));
    end

    assign ext_cap = (range_q == '0);
    assign mux_sel = {~active_side, phase == PH_CONV2};
endmodule

// File: rtl/dual_integ_sequencer.sv
module dual_integ_sequencer
    import disq_pkg::*;
#(
    parameter int CONV_CYCLES  = 2200,
    parameter int RESET_CYCLES = 100,
    parameter int RANGE_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    conv_sel,
    input  logic                    test_en,
    input  logic [RANGE_W-1:0]      range_code,
    output logic [3:0]              sw_rst,
    output logic [3:0]              sw_int,
    output logic [3:0]              sw_ref,
    output logic [3:0]              sw_adc,
    output logic [1:0]              mux_sel,
    output logic [1:0]              test_inj,
    output logic                    ext_cap,
    output logic [(2**RANGE_W)-2:0] int_range,
    output logic                    result_ready,
    output logic                    overrun
);
    logic               sel_s;
    logic               active_side;
    phase_e             phase;
    logic [RANGE_W-1:0] range_q;

    disq_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (conv_sel),
        .d_sync  (sel_s)
    );

    disq_ctrl #(
        .CONV_CYCLES  (CONV_CYCLES),
        .RESET_CYCLES (RESET_CYCLES),
        .RANGE_W      (RANGE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sel_s        (sel_s),
        .test_en      (test_en),
        .range_code   (range_code),
        .active_side  (active_side),
        .phase        (phase),
        .test_inj     (test_inj),
        .range_q      (range_q),
        .result_ready (result_ready),
        .overrun      (overrun)
    );

    disq_decode #(
        .RANGE_W (RANGE_W)
    ) u_dec (
        .active_side (active_side),
        .phase       (phase),
        .range_q     (range_q),
        .sw_rst      (sw_rst),
        .sw_int      (sw_int),
        .sw_ref      (sw_ref),
        .sw_adc      (sw_adc),
        .mux_sel     (mux_sel),
        .ext_cap     (ext_cap),
        .int_range   (int_range)
    );
endmodule

// File: rtl/disq_checker.sv
module disq_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] sw_rst,
    input logic [3:0] sw_int,
    input logic [3:0] sw_adc,
    input logic [1:0] mux_sel,
    input logic [1:0] test_inj,
    input logic       result_ready,
    input logic       overrun
);
    p_no_clash_r8: assert property (@(posedge clk) disable iff (rst)
        (sw_rst & sw_int) == 4'b0000);

    p_one_side_r1: assert property (@(posedge clk) disable iff (rst)
        (sw_int == 4'b0011) || (sw_int == 4'b1100));

    p_single_adc_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sw_adc));

    p_mux_match_r4: assert property (@(posedge clk) disable iff (rst)
        (sw_adc != 4'b0000) |-> sw_adc[mux_sel]);

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        result_ready |=> !result_ready);

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    p_test_side_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(test_inj));
endmodule

bind dual_integ_sequencer disq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .sw_rst       (sw_rst),
    .sw_int       (sw_int),
    .sw_adc       (sw_adc),
    .mux_sel      (mux_sel),
    .test_inj     (test_inj),
    .result_ready (result_ready),
    .overrun      (overrun)
);

// File: tb/tb_dual_integ_sequencer.sv
module tb_dual_integ_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CONV_N     = 8;
    localparam int CLEAR_N    = 4;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst;
    logic       conv_sel;
    logic       test_en;
    logic [2:0] range_code;
    logic [3:0] sw_rst, sw_int, sw_ref, sw_adc;
    logic [1:0] mux_sel, test_inj;
    logic       ext_cap;
    logic [6:0] int_range;
    logic       result_ready, overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_integ_sequencer #(
        .CONV_CYCLES  (CONV_N),
        .RESET_CYCLES (CLEAR_N),
        .RANGE_W      (3)
    ) dut (
        .clk(clk), .rst(rst), .conv_sel(conv_sel), .test_en(test_en),
        .range_code(range_code), .sw_rst(sw_rst), .sw_int(sw_int),
        .sw_ref(sw_ref), .sw_adc(sw_adc), .mux_sel(mux_sel),
        .test_inj(test_inj), .ext_cap(ext_cap), .int_range(int_range),
        .result_ready(result_ready), .overrun(overrun)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance n rising edges, then settle at the falling edge
    task automatic step(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; conv_sel = 1'b0; test_en = 1'b0; range_code = 3'd0;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R11 sw_int", sw_int, 4'b1100);
        chk("R11 sw_adc", sw_adc, 4'b0000);
        chk("R11 sw_rst", sw_rst, 4'b0000);
        chk("R11 ready",  result_ready, 1'b0);
        chk("R11 overrun", overrun, 1'b0);
        chk("R11 ext_cap", ext_cap, 1'b1);
        chk("R11 test_inj", test_inj, 2'b00);
    endtask

    task automatic t_cycle_side_b();
        range_code = 3'd5;
        conv_sel   = 1'b1;
        step(2);
        chk("R2 not yet swapped", sw_int, 4'b1100);
        step(1);
        chk("R1 side A integrates", sw_int, 4'b0011);
        chk("R3 conv ch1 B adc", sw_adc, 4'b0100);
        chk("R3 conv ch1 B ref", sw_ref, 4'b0100);
        chk("R4 mux ch1", mux_sel, 2'd2);
        chk("R6 range latched", int_range, 7'b0010000);
        chk("R6 ext_cap off", ext_cap, 1'b0);
        chk("R7 no test", test_inj, 2'b00);
        range_code = 3'd2;
        step(CONV_N);
        chk("R3 conv ch2 B adc", sw_adc, 4'b1000);
        chk("R4 mux ch2", mux_sel, 2'd3);
        chk("R6 range held", int_range, 7'b0010000);
        step(CONV_N);
        chk("R9 ready pulse", result_ready, 1'b1);
        chk("R5 clear B", sw_rst, 4'b1100);
        chk("R5 clear ref", sw_ref, 4'b1100);
        chk("R5 adc off", sw_adc, 4'b0000);
        step(1);
        chk("R9 ready one cycle", result_ready, 1'b0);
        step(CLEAR_N - 1);
        chk("R5 wait after clear", sw_rst | sw_ref | sw_adc, 4'b0000);
        chk("R10 no overrun", overrun, 1'b0);
    endtask

    task automatic t_test_and_ext();
        test_en    = 1'b1;
        range_code = 3'd0;
        conv_sel   = 1'b0;
        step(3);
        test_en = 1'b0;
        chk("R1 side B integrates", sw_int, 4'b1100);
        chk("R7 test on side B", test_inj, 2'b10);
        chk("R6 ext cap", ext_cap, 1'b1);
        chk("R6 no internal", int_range, 7'b0000000);
        chk("R3 conv ch1 A", sw_adc, 4'b0001);
        chk("R4 mux A ch1", mux_sel, 2'd0);
        step(2*CONV_N + CLEAR_N + 2);
        chk("R5 A parked", sw_rst | sw_adc, 4'b0000);
    endtask

    task automatic t_overrun();
        range_code = 3'd7;
        conv_sel   = 1'b1;
        step(3);
        chk("R1 A integrates again", sw_int, 4'b0011);
        chk("R6 range code 7", int_range, 7'b1000000);
        conv_sel = 1'b0;
        step(3);
        chk("R10 overrun set", overrun, 1'b1);
        chk("R10 no early swap", sw_int, 4'b0011);
        chk("R10 conv continues", sw_adc, 4'b0100);
        step(CONV_N - 3);
        chk("R10 ch2 still runs", sw_adc, 4'b1000);
        chk("R10 still A", sw_int, 4'b0011);
        step(CONV_N);
        chk("R10 deferred swap", sw_int, 4'b1100);
        chk("R10 new conv A ch1", mux_sel, 2'd0);
        chk("R9 ready at deferred end", result_ready, 1'b1);
        step(CONV_N);
        chk("R10 sticky", overrun, 1'b1);
    endtask

    initial begin
        t_reset();
        t_cycle_side_b();
        t_test_and_ext();
        t_overrun();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule